// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This is the combinational arithmetic and logic unit of a small 8-bit RISC core. Each cycle the core presents two operands, a carry input, a 5-bit operation select and the current 8-bit status byte. The unit returns the result byte, a write-enable that tells the core whether the result goes back to the destination register, and the next status byte.

Each operation updates only its own subset of the flags. Every other status bit passes through unchanged. Compares produce flags without writing a result. There is no clock and no state inside. Internally the operation select is decoded into one of four named classes: none, arithmetic, logic and shift. One unit serves each working class, and a merge stage combines the chosen unit's new flags with the incoming status byte under that unit's update mask.

Status byte bit positions, which the core's branch logic decodes: bit 7 interrupt enable (I), bit 6 transfer bit (T), bit 5 half carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C).

Top module: `alu8_core`

## Requirements
- R1: The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, AND=6, OR=7, XOR=8, COM=9, NEG=10, INC=11, DEC=12, LSL=13, LSR=14, ROL=15, ROR=16, ASR=17 and SWAP=18. Every listed code except CP and CPC raises result_we. Codes 19 to 31 lower result_we, return op_a as the result, and return sreg_in unchanged.
- R2: ADD gives op_a+op_b and ignores carry_in. ADC gives op_a+op_b+carry_in. Both set C to the carry out of bit 7, H to the carry out of bit 3, V to two's-complement overflow, N to result bit 7, and Z when the result is zero.
- R3: SUB, SBC, CP and CPC compute op_a-op_b. SBC and CPC also subtract carry_in. C is the borrow out of bit 7 and H is the borrow out of bit 3, with V, N and Z set as for addition. CP and CPC put the difference on result but keep result_we low.
- R4: AND, OR and XOR update Z and N, force V to 0, and leave C and H unchanged.
- R5: COM returns 0xFF minus op_a, sets C to 1 and V to 0, and leaves H unchanged. NEG returns 0x00 minus op_a with the subtraction flags: C is set for any nonzero operand, and V is set only for 0x80.
- R6: INC and DEC add or subtract one and update Z, N and V, with V set for 0x7F and 0x80 respectively. C and H are left unchanged.
- R7: LSL shifts left with a zero fill. LSR shifts right with a zero fill. ASR shifts right and keeps bit 7. In each case C receives the bit shifted out, V is N XOR C, Z and N follow the result, and H is unchanged.
- R8: ROL moves carry_in into bit 0 and bit 7 into C. ROR moves carry_in into bit 7 and bit 0 into C. Both set flags as in R7.
- R9: SWAP exchanges bits 7..4 with bits 3..0 and returns sreg_in unchanged.
- R10: Whenever an operation updates N or V, S equals N XOR V in sreg_out. Bits I and T of sreg_out always equal those of sreg_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DW (8) | First operand, and the destination's current value |
| op_b | input | DW (8) | Second operand, register or constant |
| carry_in | input | 1 | Carry used by ADC, SBC, CPC, ROL and ROR |
| op_sel | input | 5 | Operation code (see R1) |
| sreg_in | input | 8 | Current status byte |
| result | output | DW (8) | Operation result |
| result_we | output | 1 | High when the result is to be written back |
| sreg_out | output | 8 | Next status byte |

## Verification
The bench builds the unit with the default width of 8. This width makes it cheap to sweep all 256 values of op_a through every add and subtract variant, against a set of op_b values placed at the nibble and sign boundaries, with both carry inputs. Expected values for the sweep come from plain integer arithmetic in the bench. A hand-computed vector table covers every flag subset, the overflow points 0x7F and 0x80, the zero result, the undefined codes, and I and T passing through.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    // operation class picked by the decoder
    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_SHIFT = 2'd3
    } alu_cls_e;

    // flags a unit can produce; S is derived in the merge stage
    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    localparam int SR_C = 0;
    localparam int SR_Z = 1;
    localparam int SR_N = 2;
    localparam int SR_V = 3;
    localparam int SR_S = 4;
    localparam int SR_H = 5;
    localparam int SR_T = 6;
    localparam int SR_I = 7;

endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output alu_flags_t      flg,
    output alu_flags_t      upd
);
    localparam int MSB = DW - 1;
    localparam int HB  = DW / 2 - 1;

    logic          is_sub;
    logic          use_c;
    logic          neg_mode;
    logic          step_mode;
    logic [DW-1:0] x_opnd;
    logic [DW-1:0] y_opnd;
    logic          c_eff;
    logic [DW:0]   wide;

    // per-operation control of the shared adder
    always_comb begin
        is_sub    = 1'b0;
        use_c     = 1'b0;
        neg_mode  = 1'b0;
        step_mode = 1'b0;
        unique case (op)
            OP_ADC:          use_c = 1'b1;
            OP_SUB, OP_CP:   is_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                is_sub = 1'b1;
                use_c  = 1'b1;
            end
            OP_NEG: begin
                is_sub   = 1'b1;
                neg_mode = 1'b1;
            end
            OP_INC:          step_mode = 1'b1;
            OP_DEC: begin
                is_sub    = 1'b1;
                step_mode = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        x_opnd = neg_mode ? '0 : a;
        if (neg_mode)       y_opnd = a;
        else if (step_mode) y_opnd = {{(DW-1){1'b0}}, 1'b1};
        else                y_opnd = b;
        c_eff = use_c & cin;
        if (is_sub)
            wide = {1'b0, x_opnd} - {1'b0, y_opnd} - {{DW{1'b0}}, c_eff};
        else
            wide = {1'b0, x_opnd} + {1'b0, y_opnd} + {{DW{1'b0}}, c_eff};
        res = wide[MSB:0];
    end

    always_comb begin
        flg.c = wide[DW];
        flg.n = res[MSB];
        flg.z = (res == '0);
        if (is_sub) begin
            flg.h = (~x_opnd[HB] & y_opnd[HB]) | (y_opnd[HB] & res[HB]) |
                    (res[HB] & ~x_opnd[HB]);
            flg.v = (x_opnd[MSB] & ~y_opnd[MSB] & ~res[MSB]) |
                    (~x_opnd[MSB] & y_opnd[MSB] & res[MSB]);
        end else begin
            flg.h = (x_opnd[HB] & y_opnd[HB]) | (y_opnd[HB] & ~res[HB]) |
                    (~res[HB] & x_opnd[HB]);
            flg.v = (x_opnd[MSB] & y_opnd[MSB] & ~res[MSB]) |
                    (~x_opnd[MSB] & ~y_opnd[MSB] & res[MSB]);
        end
        // increment and decrement keep C and H
        upd.c = ~step_mode;
        upd.h = ~step_mode;
        upd.v = 1'b1;
        upd.n = 1'b1;
        upd.z = 1'b1;
    end

    always_comb begin
        if (op == OP_SUB || op == OP_CP)
            p_sub_borrow_r3: assert (flg.c == (a < b));
        if (op == OP_ADD)
            p_add_wrap_r2: assert (flg.c == (res < a));
        if (op == OP_NEG && a == '0)
            p_neg_zero_r5: assert (res == '0 && !flg.c);
    end

endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   res,
    output alu_flags_t      flg,
    output alu_flags_t      upd
);
    localparam int MSB = DW - 1;

    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            default: res = a;
        endcase
    end

    always_comb begin
        flg.h = 1'b0;
        flg.v = 1'b0;
        flg.c = 1'b1;
        flg.n = res[MSB];
        flg.z = (res == '0);
        upd.h = 1'b0;
        upd.v = 1'b1;
        upd.n = 1'b1;
        upd.z = 1'b1;
        upd.c = (op == OP_COM);
    end

    always_comb begin
        if (op == OP_COM)
            p_com_inv_r5: assert ((res ^ a) == '1);
    end

endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output alu_flags_t      flg,
    output alu_flags_t      upd
);
    localparam int MSB = DW - 1;
    localparam int HB  = DW / 2 - 1;

    logic co;

    always_comb begin
        co = 1'b0;
        unique case (op)
            OP_LSL: begin res = {a[MSB-1:0], 1'b0};  co = a[MSB]; end
            OP_LSR: begin res = {1'b0, a[MSB:1]};    co = a[0];   end
            OP_ROL: begin res = {a[MSB-1:0], cin};   co = a[MSB]; end
            OP_ROR: begin res = {cin, a[MSB:1]};     co = a[0];   end
            OP_ASR: begin res = {a[MSB], a[MSB:1]};  co = a[0];   end
            OP_SWAP: res = {a[HB:0], a[MSB:HB+1]};
            default: res = a;
        endcase
    end

    always_comb begin
        flg.h = 1'b0;
        flg.c = co;
        flg.n = res[MSB];
        flg.z = (res == '0);
        flg.v = res[MSB] ^ co;
        upd.h = 1'b0;
        upd.c = (op != OP_SWAP);
        upd.v = (op != OP_SWAP);
        upd.n = (op != OP_SWAP);
        upd.z = (op != OP_SWAP);
    end

    always_comb begin
        if (op == OP_ASR)
            p_asr_sign_r7: assert (res[MSB] == a[MSB]);
        if (op == OP_LSR)
            p_lsr_fill_r7: assert (!res[MSB]);
        if (op == OP_ROL)
            p_rol_cin_r8: assert (res[0] == cin);
        if (op == OP_ROR)
            p_ror_cin_r8: assert (res[MSB] == cin);
    end

endmodule

// File: rtl/alu8_flag_merge.sv
`timescale 1ns/1ps
module alu8_flag_merge
    import alu8_pkg::*;
(
    input  logic [7:0]  sreg_in,
    input  alu_flags_t  flg,
    input  alu_flags_t  upd,
    output logic [7:0]  sreg_out
);
    always_comb begin
        sreg_out = sreg_in;
        if (upd.c) sreg_out[SR_C] = flg.c;
        if (upd.z) sreg_out[SR_Z] = flg.z;
        if (upd.n) sreg_out[SR_N] = flg.n;
        if (upd.v) sreg_out[SR_V] = flg.v;
        if (upd.h) sreg_out[SR_H] = flg.h;
        if (upd.n || upd.v)
            sreg_out[SR_S] = sreg_out[SR_N] ^ sreg_out[SR_V];
    end

    always_comb begin
        p_keep_it_r10: assert (sreg_out[SR_I] == sreg_in[SR_I] &&
                               sreg_out[SR_T] == sreg_in[SR_T]);
        if (!upd.c)
            p_keep_c_r6: assert (sreg_out[SR_C] == sreg_in[SR_C]);
    end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          carry_in,
    input  logic [4:0]    op_sel,
    input  logic [7:0]    sreg_in,
    output logic [DW-1:0] result,
    output logic          result_we,
    output logic [7:0]    sreg_out
);
    localparam int MSB = DW - 1;

    alu_op_e    op;
    alu_cls_e   cls;
    logic [DW-1:0] ar_res, lg_res, sh_res;
    alu_flags_t ar_flg, lg_flg, sh_flg, sel_flg;
    alu_flags_t ar_upd, lg_upd, sh_upd, sel_upd;

    assign op = alu_op_e'(op_sel);

    // class decoder
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
            OP_NEG, OP_INC, OP_DEC:             cls = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM:      cls = CLS_LOGIC;
            OP_LSL, OP_LSR, OP_ROL, OP_ROR,
            OP_ASR, OP_SWAP:                    cls = CLS_SHIFT;
            default:                            cls = CLS_NONE;
        endcase
    end

    alu8_arith #(.DW(DW)) u_arith (
        .op (op), .a (op_a), .b (op_b), .cin (carry_in),
        .res (ar_res), .flg (ar_flg), .upd (ar_upd)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .op (op), .a (op_a), .b (op_b),
        .res (lg_res), .flg (lg_flg), .upd (lg_upd)
    );

    alu8_shift #(.DW(DW)) u_shift (
        .op (op), .a (op_a), .cin (carry_in),
        .res (sh_res), .flg (sh_flg), .upd (sh_upd)
    );

    // output selection per class
    always_comb begin
        unique case (cls)
            CLS_ARITH: begin
                result    = ar_res;
                sel_flg   = ar_flg;
                sel_upd   = ar_upd;
                result_we = (op != OP_CP) && (op != OP_CPC);
            end
            CLS_LOGIC: begin
                result    = lg_res;
                sel_flg   = lg_flg;
                sel_upd   = lg_upd;
                result_we = 1'b1;
            end
            CLS_SHIFT: begin
                result    = sh_res;
                sel_flg   = sh_flg;
                sel_upd   = sh_upd;
                result_we = 1'b1;
            end
            default: begin
                result    = op_a;
                sel_flg   = '0;
                sel_upd   = '0;
                result_we = 1'b0;
            end
        endcase
    end

    alu8_flag_merge u_merge (
        .sreg_in (sreg_in), .flg (sel_flg), .upd (sel_upd),
        .sreg_out (sreg_out)
    );

    always_comb begin
        if (op == OP_CP || op == OP_CPC)
            p_cmp_nowrite_r3: assert (!result_we);
        if (op == OP_SWAP)
            p_swap_flags_r9: assert (sreg_out == sreg_in);
        if (op == OP_INC || op == OP_DEC)
            p_incdec_carry_r6: assert (sreg_out[SR_C] == sreg_in[SR_C] &&
                                       sreg_out[SR_H] == sreg_in[SR_H]);
        if (op_sel > 5'd18)
            p_undef_hold_r1: assert (!result_we && sreg_out == sreg_in &&
                                     result == op_a);
        if (op == OP_AND || op == OP_OR || op == OP_XOR)
            p_logic_v_r4: assert (!sreg_out[SR_V] &&
                                  sreg_out[SR_C] == sreg_in[SR_C]);
        if (op == OP_ROL)
            p_rol_out_r8: assert (sreg_out[SR_C] == op_a[MSB]);
    end

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0, sreg_in = '0;
    logic       carry_in = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] result, sreg_out;
    logic       result_we;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_core #(.DW(8)) u_dut (
        .op_a (op_a), .op_b (op_b), .carry_in (carry_in), .op_sel (op_sel),
        .sreg_in (sreg_in), .result (result), .result_we (result_we),
        .sreg_out (sreg_out)
    );

    // {op, a, b, cin, sreg_in, exp_res, exp_we, exp_sreg}
    localparam int NV = 24;
    localparam logic [46:0] VEC [NV] = '{
        {5'd0,  8'h0F, 8'h01, 1'b0, 8'h00, 8'h10, 1'b1, 8'h20},
        {5'd0,  8'h80, 8'h80, 1'b0, 8'h00, 8'h00, 1'b1, 8'h1B},
        {5'd1,  8'h7F, 8'h00, 1'b1, 8'hC0, 8'h80, 1'b1, 8'hEC},
        {5'd2,  8'h10, 8'h01, 1'b0, 8'h00, 8'h0F, 1'b1, 8'h20},
        {5'd2,  8'h00, 8'h01, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h35},
        {5'd3,  8'h80, 8'h00, 1'b1, 8'h00, 8'h7F, 1'b1, 8'h38},
        {5'd4,  8'h42, 8'h42, 1'b0, 8'h00, 8'h00, 1'b0, 8'h02},
        {5'd5,  8'h00, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h35},
        {5'd6,  8'hF0, 8'h3C, 1'b0, 8'h2F, 8'h30, 1'b1, 8'h21},
        {5'd8,  8'h80, 8'h01, 1'b0, 8'h00, 8'h81, 1'b1, 8'h14},
        {5'd7,  8'h00, 8'h00, 1'b0, 8'h08, 8'h00, 1'b1, 8'h02},
        {5'd9,  8'h55, 8'h00, 1'b0, 8'h00, 8'hAA, 1'b1, 8'h15},
        {5'd10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80, 1'b1, 8'h0D},
        {5'd10, 8'h01, 8'h00, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h35},
        {5'd11, 8'h7F, 8'h00, 1'b0, 8'h01, 8'h80, 1'b1, 8'h0D},
        {5'd12, 8'h80, 8'h00, 1'b0, 8'h21, 8'h7F, 1'b1, 8'h39},
        {5'd12, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h02},
        {5'd13, 8'h81, 8'h00, 1'b0, 8'h00, 8'h02, 1'b1, 8'h19},
        {5'd14, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h1B},
        {5'd17, 8'h81, 8'h00, 1'b0, 8'h00, 8'hC0, 1'b1, 8'h15},
        {5'd15, 8'h80, 8'h00, 1'b1, 8'h00, 8'h01, 1'b1, 8'h19},
        {5'd16, 8'h02, 8'h00, 1'b1, 8'h00, 8'h81, 1'b1, 8'h0C},
        {5'd18, 8'hA5, 8'h00, 1'b0, 8'h5A, 8'h5A, 1'b1, 8'h5A},
        {5'd31, 8'h33, 8'h00, 1'b1, 8'hFF, 8'h33, 1'b0, 8'hFF}
    };

    function automatic string req_of(int op);
        if (op <= 1)       return "R2";
        else if (op <= 5)  return "R3";
        else if (op <= 8)  return "R4";
        else if (op <= 10) return "R5";
        else if (op <= 12) return "R6";
        else if (op == 13 || op == 14 || op == 17) return "R7";
        else if (op <= 16) return "R8";
        else if (op == 18) return "R9";
        return "R1";
    endfunction

    task automatic drive(input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic c,
                         input logic [7:0] s);
        @(posedge clk);
        #1;
        op_sel = op; op_a = a; op_b = b; carry_in = c; sreg_in = s;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [16:0] act,
                         input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h we=%b sreg=%h, expected res=%h we=%b sreg=%h",
                     tag, act[16:9], act[8], act[7:0], exp[16:9], exp[8], exp[7:0]);
        end
    endtask

    // expected add/subtract outcome from integer arithmetic (R2, R3, R10)
    function automatic logic [16:0] ref_arith(int op, int a, int b, int c,
                                              logic [7:0] s);
        int cc, full, lo, sa, sb, sf;
        logic [7:0] r;
        logic fc, fh, fv, fn, fz;
        cc = (op == 1 || op == 3) ? c : 0;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        if (op >= 2) begin
            full = a - b - cc; lo = (a % 16) - (b % 16) - cc; sf = sa - sb - cc;
            fc = (full < 0); fh = (lo < 0);
        end else begin
            full = a + b + cc; lo = (a % 16) + (b % 16) + cc; sf = sa + sb + cc;
            fc = (full > 255); fh = (lo > 15);
        end
        fv = (sf > 127) || (sf < -128);
        r  = full[7:0];
        fn = r[7];
        fz = (r == 8'h00);
        return {r, 1'b1, s[7], s[6], fh, fn ^ fv, fv, fn, fz, fc};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] bset [6];
        bset = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hFF};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset/idle state: all-zero inputs select ADD 0+0 (R2)
        @(negedge clk);
        check("R2 idle zero add", {result, result_we, sreg_out},
              {8'h00, 1'b1, 8'h02});

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][46:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25],
                  VEC[i][24:17]);
            check($sformatf("%s vec %0d", req_of(int'(VEC[i][46:42])), i),
                  {result, result_we, sreg_out}, VEC[i][16:0]);
        end

        // every undefined code holds state (R1)
        for (int k = 19; k < 32; k++) begin
            drive(5'(k), 8'hC3, 8'h11, 1'b1, 8'h96);
            check("R1 undefined code", {result, result_we, sreg_out},
                  {8'hC3, 1'b0, 8'h96});
        end

        // I/T pass-through on a shift with all flags preset (R10)
        drive(5'd14, 8'h02, 8'h00, 1'b0, 8'hFF);
        check("R10 I/T kept on LSR", {result, result_we, sreg_out},
              {8'h01, 1'b1, 8'hE0});

        // sweep add/subtract variants, sreg_in with I and T set (R2, R3, R10)
        for (int op = 0; op < 4; op++) begin
            for (int bi = 0; bi < 6; bi++) begin
                for (int a = 0; a < 256; a++) begin
                    for (int c = 0; c < 2; c++) begin
                        drive(5'(op), 8'(a), bset[bi], c[0], 8'hC0);
                        check((op < 2) ? "R2 add sweep" : "R3 sub sweep",
                              {result, result_we, sreg_out},
                              ref_arith(op, a, int'(bset[bi]), c, 8'hC0));
                    end
                end
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule